// File: doc/BRIEF.md
# Four-Port Power Switch Sequencer

This block decides when each of four powered ports may switch its supply on or off. A port that has passed classification raises a turn-on request. The sequencer grants these requests one at a time. Each grant is followed by a startup window, and the next port may not begin to turn on until that window ends. Turn-off commands are serialised in the same way: each shutdown opens a quiet window, and no other port may turn off while it runs. When several ports ask in the same cycle, the port with the lowest index is served first. This ordering applies to turn-on and to turn-off.

An emergency input, either a port-level reset or a thermal shutdown, overrides both windows and drops every port at once. For each port the block also qualifies the power-OK comparator into a power-good bit. It publishes a powered status bit and a one-cycle change pulse whenever that status moves. An optional oscillator check, when enabled, blocks new turn-ons while the oscillator is reported as failed.

All window lengths are parameters counted in clock cycles. The defaults correspond to a 250 MHz clock.

Top module: `pwr_seq_arbiter`

## Requirements
- R1: When several ports are eligible for the same action in one cycle, only the lowest-indexed one is granted (bit 0 is port 1, the highest priority), for both turn-on and turn-off.
- R2: A turn-on grant raises that port's `gate_en` at the next edge and opens a startup window. The port's `pwr_en` rises START_CYC edges after `gate_en`. No other `gate_en` may rise until the edge after `pwr_en` rose.
- R3: While `acd_en` and `osc_fail` are both high, no `gate_en` rises. Ports that are already on are not affected.
- R4: `off_cmd` on a port whose `pwr_en` is high clears its `gate_en` and `pwr_en` at the next edge and opens a shutdown window of SHUT_CYC cycles. No other port turns off during that window, so the next turn-off comes at least SHUT_CYC+1 edges later.
- R5: While `emerg_rst` or `therm_shdn` is high, every `gate_en` and `pwr_en` is low from the next edge onward, both windows are cancelled, and no turn-on is granted.
- R6: `pgood` of a port goes high once `pok` and `gate_en` of that port have been high at PGQ_CYC+1 consecutive edges. It goes low at the first edge at which either of them is low.
- R7: `pg_chg` of a port is high for exactly the cycle following each edge at which that port's `pwr_en` changed value, and is low otherwise.
- R8: A port whose `off_cmd` is high is never granted a turn-on, even when its `on_req` is high.
- R9: After a synchronous reset, with `rst_n` low, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| on_req | input | N | Per-port turn-on request after classification |
| off_cmd | input | N | Per-port turn-off command |
| pok | input | N | Per-port power-OK comparator |
| acd_en | input | 1 | Enables the oscillator check before turn-on |
| osc_fail | input | 1 | Oscillator failure flag |
| emerg_rst | input | 1 | Emergency port reset |
| therm_shdn | input | 1 | Thermal shutdown |
| gate_en | output | N | Per-port power switch enable |
| pwr_en | output | N | Per-port powered status |
| pgood | output | N | Per-port qualified power-good |
| pg_chg | output | N | Per-port one-cycle pulse on powered-status change |

## Verification
The hardest situation to reach is two or more powered ports asking to turn off while a shutdown window is still running. Before that can happen, all four ports must have been brought up one by one through their startup windows. A directed sequence first powers every port. It then raises all turn-off commands together, so that the priority order and the quiet-window spacing both show in the order in which the ports fall. Random phases then mix requests, power-OK dropouts, oscillator failures and short emergencies against a cycle model in the bench.

// File: rtl/pwr_seq_pkg.sv
// Shared helpers for the power sequencer.
// Assumes one-hot vectors of at most 32 bits.
package pwr_seq_pkg;

    // Index of the single set bit of a one-hot vector (0 when empty).
    function automatic int unsigned oh_index(input logic [31:0] v);
        int unsigned idx;
        idx = 0;
        for (int i = 0; i < 32; i++) begin
            if (v[i]) idx = i;
        end
        return idx;
    endfunction

endpackage

// File: rtl/prio_pick.sv
// Fixed-priority picker: keeps only the lowest set bit of req.
// Assumes N >= 1; purely combinational.
module prio_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    logic [N:0] seen;

    assign seen[0] = 1'b0;

    // Chain of "a lower bit already asked" flags.
    for (genvar i = 0; i < N; i++) begin : g_chain
        assign seen[i+1] = seen[i] | req[i];
        assign grant[i]  = req[i] & ~seen[i];
    end

    always_comb begin
        assert (!(|(grant & (grant - 1'b1))))
            else $error("AST_GRANT_ONEHOT");  // R1
    end
endmodule

// File: rtl/window_timer.sv
// One-shot window: start opens a window of CYC cycles; done is high in
// its last cycle. abort closes it at once. Assumes CYC >= 1 and that
// start is only raised while the window is closed.
module window_timer #(
    parameter int CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYC - 1);

    logic [CW-1:0] cnt;

    // Load, count down and close the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (abort) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= LOAD;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    assign done = busy && (cnt == '0);

    AST_START_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy) else $error("AST_START_WHILE_IDLE");  // R2
endmodule

// File: rtl/pg_qualifier.sv
// Power-good qualifier for one port: rises after pok and the gate have
// been high at QCYC+1 consecutive edges, falls at the first low sample.
// Assumes QCYC >= 1.
module pg_qualifier #(
    parameter int QCYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pok,
    input  logic gate,
    output logic pgood
);
    localparam int CW = $clog2(QCYC + 1);
    localparam logic [CW-1:0] LIM = CW'(QCYC);

    logic [CW-1:0] cnt;
    logic          live;

    assign live = pok & gate;

    // Count consecutive good samples and set or clear pgood.
    always_ff @(posedge clk) begin
        if (!rst_n || !live) begin
            cnt   <= '0;
            pgood <= 1'b0;
        end else if (cnt == LIM) begin
            pgood <= 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_PG_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !pok |=> !pgood) else $error("AST_PG_DROP");  // R6
    AST_PG_NEEDS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !gate |=> !pgood) else $error("AST_PG_NEEDS_GATE");  // R6
endmodule

// File: rtl/pwr_seq_arbiter.sv
// Four-port power sequencer. Grants turn-ons one at a time with a startup
// window, spaces turn-offs by a shutdown window, lowest index first for
// both, drops all ports on emergency and qualifies power-good per port.
// Assumes all inputs are synchronous to clk; window lengths are >= 1.
module pwr_seq_arbiter
    import pwr_seq_pkg::*;
#(
    parameter int N         = 4,
    parameter int START_CYC = 62500,
    parameter int SHUT_CYC  = 125000,
    parameter int PGQ_CYC   = 250000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] on_req,
    input  logic [N-1:0] off_cmd,
    input  logic [N-1:0] pok,
    input  logic         acd_en,
    input  logic         osc_fail,
    input  logic         emerg_rst,
    input  logic         therm_shdn,
    output logic [N-1:0] gate_en,
    output logic [N-1:0] pwr_en,
    output logic [N-1:0] pgood,
    output logic [N-1:0] pg_chg
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic          emerg, osc_block;
    logic [N-1:0]  on_elig, off_elig, on_grant, off_grant;
    logic [N-1:0]  gate_q, pwr_q, chg_q, gate_d, pwr_d, done_vec;
    logic          st_busy, st_done, sh_busy, sh_done;
    logic [IW-1:0] st_port;

    assign emerg     = emerg_rst | therm_shdn;
    assign osc_block = acd_en & osc_fail;

    // Ports that may be granted a turn-on or a turn-off this cycle.
    always_comb begin
        on_elig  = on_req & ~gate_q & ~off_cmd
                   & {N{~st_busy & ~osc_block & ~emerg}};
        off_elig = off_cmd & pwr_q & {N{~sh_busy & ~emerg}};
    end

    prio_pick #(.N(N)) u_on_pick  (.req(on_elig),  .grant(on_grant));
    prio_pick #(.N(N)) u_off_pick (.req(off_elig), .grant(off_grant));

    window_timer #(.CYC(START_CYC)) u_start_win (
        .clk(clk), .rst_n(rst_n), .start(|on_grant), .abort(emerg),
        .busy(st_busy), .done(st_done)
    );

    window_timer #(.CYC(SHUT_CYC)) u_shut_win (
        .clk(clk), .rst_n(rst_n), .start(|off_grant), .abort(emerg),
        .busy(sh_busy), .done(sh_done)
    );

    // Next gate and powered state from grants, window end and emergency.
    always_comb begin
        done_vec = '0;
        if (st_done) done_vec[st_port] = 1'b1;
        if (emerg) begin
            gate_d = '0;
            pwr_d  = '0;
        end else begin
            gate_d = (gate_q | on_grant) & ~off_grant;
            pwr_d  = (pwr_q | done_vec) & ~off_grant;
        end
    end

    // Port state registers and the change pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= '0;
            pwr_q  <= '0;
            chg_q  <= '0;
        end else begin
            gate_q <= gate_d;
            pwr_q  <= pwr_d;
            chg_q  <= pwr_d ^ pwr_q;
        end
    end

    // Remember which port owns the startup window.
    always_ff @(posedge clk) begin
        if (!rst_n)         st_port <= '0;
        else if (|on_grant) st_port <= IW'(oh_index(32'(on_grant)));
    end

    for (genvar i = 0; i < N; i++) begin : g_pg
        pg_qualifier #(.QCYC(PGQ_CYC)) u_pgq (
            .clk(clk), .rst_n(rst_n), .pok(pok[i]), .gate(gate_q[i]),
            .pgood(pgood[i])
        );
    end

    assign gate_en = gate_q;
    assign pwr_en  = pwr_q;
    assign pg_chg  = chg_q;

    AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        |on_elig |=> $countones(gate_q & ~$past(gate_q)) == 1) else $error("AST_LOWEST_FIRST");  // R1
    AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
        |(gate_q & ~$past(gate_q)) |-> !$past(st_busy)) else $error("AST_ONE_START");  // R2
    AST_OSC_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        |(gate_q & ~$past(gate_q)) |-> !($past(acd_en) && $past(osc_fail))) else $error("AST_OSC_BLOCK");  // R3
    AST_SHUT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~pwr_q & $past(pwr_q)) && !$past(emerg)) |-> !$past(sh_busy)) else $error("AST_SHUT_GAP");  // R4
    AST_EMERG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        emerg |=> (gate_q == '0 && pwr_q == '0)) else $error("AST_EMERG_OFF");  // R5
    AST_CHG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pg_chg == (pwr_q ^ $past(pwr_q)))) else $error("AST_CHG_PULSE");  // R7
    AST_OFF_MASKS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        |(off_cmd & ~gate_q) |=> !(|($past(off_cmd) & ~$past(gate_q) & gate_q))) else $error("AST_OFF_MASKS_ON");  // R8
endmodule

// File: tb/pwr_seq_arbiter_test.sv
module pwr_seq_arbiter_test;
    localparam int N = 4, STC = 3, SHC = 5, PGQ = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [N-1:0] on_req = '0, off_cmd = '0, pok = '0;
    logic acd_en = 1'b0, osc_fail = 1'b0, emerg_rst = 1'b0, therm_shdn = 1'b0;
    logic [N-1:0] gate_en, pwr_en, pgood, pg_chg;

    int n_chk = 0, n_bad = 0;

    // cycle model state
    logic [N-1:0] m_gate, m_pwr, m_pg, m_chg;
    int m_cnt [N];
    bit m_stb, m_shb;
    int m_stc, m_shc, m_stp;

    always #2 clk = ~clk;

    pwr_seq_arbiter #(.N(N), .START_CYC(STC), .SHUT_CYC(SHC), .PGQ_CYC(PGQ)) uut (
        .clk(clk), .rst_n(rst_n), .on_req(on_req), .off_cmd(off_cmd), .pok(pok),
        .acd_en(acd_en), .osc_fail(osc_fail), .emerg_rst(emerg_rst),
        .therm_shdn(therm_shdn), .gate_en(gate_en), .pwr_en(pwr_en),
        .pgood(pgood), .pg_chg(pg_chg)
    );

    function automatic logic [N-1:0] lowest(input logic [N-1:0] v);
        return v & (~v + 1'b1);
    endfunction

    function automatic int idx_of(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return 0;
    endfunction

    // Cycle model built from the requirements.
    always @(posedge clk) begin
        logic em;
        logic [N-1:0] g_on, g_off, np, ng, dv;
        if (!rst_n) begin
            m_gate = '0; m_pwr = '0; m_pg = '0; m_chg = '0;
            m_stb = 0; m_shb = 0; m_stc = 0; m_shc = 0; m_stp = 0;
            for (int i = 0; i < N; i++) m_cnt[i] = 0;
        end else begin
            em    = emerg_rst | therm_shdn;
            g_on  = (m_stb || (acd_en && osc_fail) || em) ? '0
                    : lowest(on_req & ~m_gate & ~off_cmd);
            g_off = (m_shb || em) ? '0 : lowest(off_cmd & m_pwr);
            dv = '0;
            if (m_stb && m_stc == 0) dv[m_stp] = 1'b1;
            np = em ? '0 : (m_pwr | dv) & ~g_off;
            ng = em ? '0 : (m_gate | g_on) & ~g_off;
            for (int i = 0; i < N; i++) begin
                if (pok[i] && m_gate[i]) begin
                    if (m_cnt[i] == PGQ) m_pg[i] = 1'b1;
                    else m_cnt[i]++;
                end else begin
                    m_cnt[i] = 0; m_pg[i] = 1'b0;
                end
            end
            if (em) m_stb = 0;
            else if (g_on != 0) begin m_stb = 1; m_stc = STC - 1; m_stp = idx_of(g_on); end
            else if (m_stb) begin if (m_stc == 0) m_stb = 0; else m_stc--; end
            if (em) m_shb = 0;
            else if (g_off != 0) begin m_shb = 1; m_shc = SHC - 1; end
            else if (m_shb) begin if (m_shc == 0) m_shb = 0; else m_shc--; end
            m_chg = np ^ m_pwr;
            m_pwr = np; m_gate = ng;
        end
    end

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Compare all outputs to the model, then advance one cycle.
    task automatic step();
        @(negedge clk);
        chk("R1/R2/R5 gate_en", gate_en, m_gate);
        chk("R2/R4 pwr_en", pwr_en, m_pwr);
        chk("R6 pgood", pgood, m_pg);
        chk("R7 pg_chg", pg_chg, m_chg);
    endtask

    task automatic run(input int n);
        for (int k = 0; k < n; k++) begin
            step();
            pok = gate_en;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 reset gate_en", gate_en, '0);
        chk("R9 reset pgood", pgood | pwr_en | pg_chg, '0);
        rst_n = 1'b1;
        step();

        // R1: all four ask at once, port index 0 first
        on_req = 4'b1111;
        step();
        chk("R1 first grant", gate_en, 4'b0001);
        run(STC + 1);
        chk("R2 second grant after window", gate_en, 4'b0011);
        run(3 * (STC + 1) + PGQ + 4);
        chk("R2 all powered", pwr_en, 4'b1111);
        chk("R6 all good", pgood, 4'b1111);

        // R4/R1: all off at once, lowest falls first, spaced by window
        off_cmd = 4'b1111;
        step();
        chk("R4 first off", pwr_en, 4'b1110);
        run(SHC);
        chk("R4 still spaced", pwr_en, 4'b1110);
        run(1);
        chk("R4 second off", pwr_en, 4'b1100);
        // R8: on_req still high, off_cmd masks re-turn-on
        run(3 * (SHC + 1));
        chk("R8 masked", gate_en, '0);

        // R3: oscillator fail blocks turn-on
        off_cmd = '0; acd_en = 1'b1; osc_fail = 1'b1;
        run(5);
        chk("R3 blocked", gate_en, '0);
        osc_fail = 1'b0;
        run(2);
        chk("R3 released", gate_en, 4'b0001);
        run(4 * (STC + 1) + 2);

        // R5: emergency drops all at once
        therm_shdn = 1'b1;
        step();
        chk("R5 emergency", gate_en | pwr_en, '0);
        run(3);
        therm_shdn = 1'b0;
        run(20);

        // Random phase against the model.
        for (int k = 0; k < 6000; k++) begin
            step();
            on_req     = 4'($urandom);
            off_cmd    = (($urandom % 4) == 0) ? 4'($urandom) : '0;
            pok        = gate_en & ((($urandom % 10) == 0) ? 4'($urandom) : 4'hF);
            acd_en     = $urandom % 2;
            osc_fail   = ($urandom % 8) == 0;
            emerg_rst  = ($urandom % 200) == 0;
            therm_shdn = ($urandom % 300) == 0;
        end
        step();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule